// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a two-wire serial memory's bus controller and its storage array. The controller loads a start address and then hands over received data bytes one at a time. The block keeps them in a 16-byte staging buffer and marks each byte position that has been filled. The buffer position is the low four bits of the address. The upper seven bits pick an aligned 16-byte page and stay fixed for the whole transfer. When the position passes the end of the page it wraps back to the start of the same page. It never carries into the next page, so a long burst overwrites its own earliest bytes.

Nothing reaches the array until the controller reports a stop condition. On a stop with at least one buffered byte, the block starts one self-timed write cycle. The cycle length is a parameter given in clock cycles. During the cycle `busy` stays high and the marked bytes are written to the array, in ascending slot order, through a one-byte write port. A repeated start discards the buffer. So does a stop that arrives with nothing buffered. A high write-protect level at the stop also discards the buffer, and in that case `busy` is never raised. The controller is expected to stop acknowledging while `busy` is high, and the block itself ignores every input strobe during that time.

Top module: `page_commit_buf`

## Requirements
- R1: After reset `busy` is low and `arr_we` is low.
- R2: Every array write has address bits [10:4] equal to bits [10:4] of the last loaded start address. Bits [3:0] are the buffer slot. Starting from the loaded low nibble, the slot advances by one per byte and wraps from 15 to 0.
- R3: When more than 16 bytes arrive before the stop, each slot commits the last byte written to it.
- R4: A cycle writes exactly the slots that received a byte since the last address load, one write per slot. Every other address of the page keeps its old contents.
- R5: `arr_we` is never high while `busy` is low. No array write happens before the stop.
- R6: A stop with buffered bytes and write-protect low raises `busy` on the next cycle. `busy` then stays high for exactly CYCLE_CLKS cycles.
- R7: A stop with no byte buffered raises no cycle and writes nothing.
- R8: A repeated-start strobe raises no cycle and empties the buffer, so its bytes are never written.
- R9: With `wr_protect` high at the stop, `busy` stays low and no byte is written. Data strobes before the stop are still taken.
- R10: While `busy` is high, address loads, data strobes and stops have no effect on the array, on the buffer or on `busy`.
- R11: A single-byte transfer uses the same commit path as a page write.
- R12: Within one cycle, the array writes come in strictly ascending slot order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Strobe: take `load_addr` as the transfer start address |
| load_addr | input | 11 | Start address (page in [10:4], slot in [3:0]) |
| byte_valid | input | 1 | Strobe: one received data byte on `byte_data` |
| byte_data | input | 8 | Received data byte |
| stop_evt | input | 1 | Strobe: stop condition seen on the bus |
| restart_evt | input | 1 | Strobe: repeated start, aborts the pending write |
| wr_protect | input | 1 | High blocks any commit |
| busy | output | 1 | Self-timed write cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 11 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
Directed transfers run first. They cover a single byte, a full page that starts mid-page and must wrap, a 20-byte overrun, an empty stop, a repeated-start abort, a protected stop, and a commit hit by stray strobes while busy. Together they separate correct wrapping from carrying into the next page, and last-writer-wins from first-writer-wins. They also show that a valid mask differs from writing the whole page. Randomized transfers follow, with random start addresses, lengths from 0 to 20, gaps between bytes, and occasional protect or abort. After each transfer the captured array contents, the number of writes and the length of `busy` are compared with a bench model. This catches buffers that are not cleared between transfers and faults in pointer bookkeeping that only show across several transfers.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int DEF_ADDR_W = 11;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_IDX_W  = 4;

    // Decoded bus event, highest priority first in the decoder
    typedef enum logic [2:0] {
        EV_IDLE,
        EV_DROP,
        EV_END,
        EV_LOAD,
        EV_BYTE
    } bus_ev_e;

endpackage

// File: rtl/pcb_page_store.sv
module pcb_page_store #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);

    localparam int SLOTS = 1 << IDX_W;

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] data;
        logic [SLOTS-1:0]             mask;
    } store_t;

    store_t st_d, st_q;
    logic [SLOTS-1:0] hit;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign hit[i] = wr_en && (wr_idx == IDX_W'(i));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < SLOTS; i++) begin
            if (clr) begin
                st_d.mask[i] = 1'b0;
            end else if (hit[i]) begin
                st_d.data[i] = wr_data;
                st_d.mask[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.data[rd_idx];
    assign rd_valid  = st_q.mask[rd_idx];
    assign any_valid = |st_q.mask;

endmodule

// File: rtl/pcb_cycle_timer.sv
module pcb_cycle_timer #(
    parameter int CYCLE_CLKS = 1_000_000,
    localparam int CNT_W     = $clog2(CYCLE_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tm_d, tm_q;
    logic last;

    assign last = tm_q.busy && (tm_q.cnt == CNT_W'(CYCLE_CLKS - 1));

    always_comb begin
        tm_d = tm_q;
        if (!tm_q.busy) begin
            if (start) begin
                tm_d.busy = 1'b1;
                tm_d.cnt  = '0;
            end
        end else if (last) begin
            tm_d.busy = 1'b0;
            tm_d.cnt  = '0;
        end else begin
            tm_d.cnt = tm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign busy = tm_q.busy;
    assign cnt  = tm_q.cnt;
    assign done = last;

endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
    import pcb_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int IDX_W      = DEF_IDX_W,
    parameter int CYCLE_CLKS = 1_000_000   // must be at least 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_evt,
    input  logic              restart_evt,
    input  logic              wr_protect,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);

    localparam int SLOTS  = 1 << IDX_W;
    localparam int PAGE_W = ADDR_W - IDX_W;
    localparam int CNT_W  = $clog2(CYCLE_CLKS + 1);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [IDX_W-1:0]  idx;
    } ptr_t;

    ptr_t    ptr_d, ptr_q;
    bus_ev_e ev;

    logic              start, clr, wr_en, done;
    logic              any_valid, rd_valid, in_scan;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  scan_idx;
    logic [DATA_W-1:0] rd_data;

    // Event decode: every strobe is dropped while the write cycle runs
    always_comb begin
        if (busy)             ev = EV_IDLE;
        else if (restart_evt) ev = EV_DROP;
        else if (stop_evt)    ev = EV_END;
        else if (addr_load)   ev = EV_LOAD;
        else if (byte_valid)  ev = EV_BYTE;
        else                  ev = EV_IDLE;
    end

    assign start = (ev == EV_END) && any_valid && !wr_protect;
    assign wr_en = (ev == EV_BYTE);
    assign clr   = (ev == EV_DROP) || (ev == EV_LOAD)
                || ((ev == EV_END) && !start) || done;

    // Write pointer: page fixed by the load, slot wraps inside the page
    always_comb begin
        ptr_d = ptr_q;
        if (ev == EV_LOAD) begin
            ptr_d.page = load_addr[ADDR_W-1:IDX_W];
            ptr_d.idx  = load_addr[IDX_W-1:0];
        end else if (ev == EV_BYTE) begin
            ptr_d.idx = ptr_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    pcb_page_store #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_idx    (ptr_q.idx),
        .wr_data   (byte_data),
        .rd_idx    (scan_idx),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pcb_cycle_timer #(
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .cnt   (cnt),
        .done  (done)
    );

    // Commit scan: the first SLOTS cycles of the timed window walk the slots
    assign scan_idx  = cnt[IDX_W-1:0];
    assign in_scan   = busy && (cnt < CNT_W'(SLOTS));
    assign arr_we    = in_scan && rd_valid;
    assign arr_addr  = {ptr_q.page, scan_idx};
    assign arr_wdata = rd_data;

endmodule

// File: rtl/page_commit_buf_chk.sv
module page_commit_buf_chk #(
    parameter int ADDR_W     = 11,
    parameter int IDX_W      = 4,
    parameter int CYCLE_CLKS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_evt,
    input logic              restart_evt,
    input logic              wr_protect,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);

    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !arr_we) else $error("idle write"); // R5

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == CYCLE_CLKS) else $error("busy length"); // R6

    AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && wr_protect && !busy) |=> !busy) else $error("protect"); // R9

    AST_ABORT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_evt && !busy) |=> !busy) else $error("abort"); // R8

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> arr_addr[ADDR_W-1:IDX_W] == $past(arr_addr[ADDR_W-1:IDX_W]))
        else $error("page moved"); // R2

    AST_SLOT_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && busy && $past(busy)) |-> arr_addr[IDX_W-1:0] > $past(arr_addr[IDX_W-1:0]) || !$past(arr_we))
        else $error("order"); // R12

endmodule

bind page_commit_buf page_commit_buf_chk #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .CYCLE_CLKS (CYCLE_CLKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_evt    (stop_evt),
    .restart_evt (restart_evt),
    .wr_protect  (wr_protect),
    .busy        (busy),
    .arr_we      (arr_we),
    .arr_addr    (arr_addr)
);

// File: tb/page_commit_buf_tb.sv
`timescale 1ns/1ps
module page_commit_buf_tb;

    localparam int W = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load = 1'b0;
    logic [10:0] load_addr = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_evt = 1'b0;
    logic        restart_evt = 1'b0;
    logic        wr_protect = 1'b0;
    logic        busy, arr_we;
    logic [10:0] arr_addr;
    logic [7:0]  arr_wdata;

    logic [7:0] act_mem [0:2047];
    logic [7:0] exp_mem [0:2047];
    int wr_cnt = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    page_commit_buf #(.CYCLE_CLKS(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .load_addr(load_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop_evt(stop_evt),
        .restart_evt(restart_evt), .wr_protect(wr_protect), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    // Capture array writes with the pre-edge register values
    always @(posedge clk) begin
        if (arr_we) begin
            act_mem[arr_addr] = arr_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string no_start_req(input bit rs, input bit wp);
        if (rs)      return "R8";
        else if (wp) return "R9";
        else         return "R7";
    endfunction

    task automatic xfer(input logic [10:0] a, input int n, input bit wp,
                        input bit rs, input bit poke, input string tag);
        logic [7:0]  mb [16];
        logic [15:0] mk;
        logic [3:0]  ix;
        logic [7:0]  d;
        int          busy_n, bad, first_j;
        bit          go;
        mk = '0;
        ix = a[3:0];
        wr_cnt = 0;
        @(negedge clk);
        wr_protect = wp; addr_load = 1'b1; load_addr = a;
        @(negedge clk);
        addr_load = 1'b0;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            byte_valid = 1'b1; byte_data = d;
            mb[ix] = d; mk[ix] = 1'b1; ix = ix + 1'b1;
            @(negedge clk);
            byte_valid = 1'b0;
            if ($urandom % 4 == 0) @(negedge clk);
        end
        check(wr_cnt == 0, "R5 no write before stop", wr_cnt, 0);
        if (rs) restart_evt = 1'b1; else stop_evt = 1'b1;
        @(negedge clk);
        restart_evt = 1'b0; stop_evt = 1'b0;
        go = !rs && (mk != 0) && !wp;
        check(busy == go, go ? {"R6 busy rise ", tag} : no_start_req(rs, wp), busy, go);
        busy_n = 0;
        while (busy && busy_n < 1000) begin
            busy_n++;
            if (poke && busy_n == 3) begin addr_load = 1'b1; load_addr = 11'h555; end
            if (poke && busy_n == 4) begin byte_valid = 1'b1; byte_data = 8'hEE; end
            if (poke && busy_n == 5) stop_evt = 1'b1;
            @(negedge clk);
            addr_load = 1'b0; byte_valid = 1'b0; stop_evt = 1'b0;
        end
        if (go) check(busy_n == W, "R6 busy length", busy_n, W);
        @(negedge clk);
        @(negedge clk);
        check(!busy, poke ? "R10 stop while busy ignored" : "R6 busy stays low", busy, 0);
        if (go) begin
            for (int j = 0; j < 16; j++)
                if (mk[j]) exp_mem[{a[10:4], 4'(j)}] = mb[j];
        end
        check(wr_cnt == (go ? $countones(mk) : 0), {"R4 write count ", tag},
              wr_cnt, go ? $countones(mk) : 0);
        bad = 0; first_j = 0;
        for (int j = 0; j < 16; j++) begin
            if (act_mem[{a[10:4], 4'(j)}] !== exp_mem[{a[10:4], 4'(j)}]) begin
                if (bad == 0) first_j = j;
                bad++;
            end
        end
        check(bad == 0, {"R2/R3/R4 page contents ", tag},
              int'(act_mem[{a[10:4], 4'(first_j)}]), int'(exp_mem[{a[10:4], 4'(first_j)}]));
        if (poke) check(act_mem[11'h555] === exp_mem[11'h555], "R10 no write from ignored strobes",
                        int'(act_mem[11'h555]), int'(exp_mem[11'h555]));
        wr_protect = 1'b0;
    endtask

    initial begin
        for (int k = 0; k < 2048; k++) begin act_mem[k] = 8'h00; exp_mem[k] = 8'h00; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(arr_we == 1'b0, "R1 no write in reset", arr_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && arr_we == 1'b0, "R1 idle after release", {busy, arr_we}, 0);

        xfer(11'h123, 1,  0, 0, 0, "R11 single byte");
        xfer(11'h3F5, 16, 0, 0, 0, "R2 wrap in page");
        xfer(11'h0A0, 20, 0, 0, 0, "R3 overrun");
        xfer(11'h2C4, 0,  0, 0, 0, "R7 empty stop");
        xfer(11'h4E0, 5,  0, 1, 0, "R8 abort");
        // stop after abort with no new bytes: buffer must be empty (R8)
        wr_cnt = 0;
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
        check(busy == 1'b0, "R8 buffer emptied by abort", busy, 0);
        xfer(11'h7F0, 6,  1, 0, 0, "R9 protected");
        xfer(11'h200, 3,  0, 0, 1, "R10 strobes while busy");
        xfer(11'h205, 4,  0, 0, 0, "R4 partial page keeps neighbours");

        for (int t = 0; t < 30; t++) begin
            logic [10:0] ra;
            int rn;
            bit rwp, rrs;
            ra  = 11'($urandom);
            rn  = $urandom % 21;
            rwp = ($urandom % 8) == 0;
            rrs = ($urandom % 8) == 0;
            xfer(ra, rn, rwp, rrs, 0, "random");
        end

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule